// File: doc/BRIEF.md
# Store Set Memory Dependence Predictor

This block sits beside the dispatch stage of an out-of-order core and tells each dispatched load or store whether it must wait for an earlier store. Every memory instruction presents its word PC and its in-flight sequence tag. The PC is folded into an index for a table of set identifiers. A valid identifier then selects an entry in a second table, which holds the tag of the most recently dispatched store of that set. If that entry is valid, the instruction is told to wait, and the entry's tag names the store it waits for.

When the core detects an ordering violation, it reports the PC of the offending load and the PC of the offending store on the training port. The block then allocates, copies or merges set identifiers under four fixed rules, and merging always favours the smaller identifier. A separate release check tells the scheduler when a waiting load may issue: either the named store has left the store queue, or retirement has moved past it. The identifier table is flushed once the number of valid entries reaches a selectable share of its size.

Top module: `storeSetPredictor`

## Requirements
- R1: After reset, no dispatched instruction is told to wait (dispWait low).
- R2: The identifier-table index is the XOR of the 4-bit slices of the 14-bit word PC, with the top slice zero-extended: pc[3:0]^pc[7:4]^pc[11:8]^{2'b00,pc[13:12]}. Two PCs with equal folds share one entry.
- R3: A violation in which neither the load entry nor the store entry is valid writes a fresh identifier into both entries. Fresh identifiers come from a wrapping counter that starts at 0 after reset.
- R4: If only the load entry is valid, the store entry receives the load's identifier. If only the store entry is valid, the load entry receives the store's identifier.
- R5: If both entries are valid with different identifiers, the entry holding the larger identifier is overwritten with the smaller one. The other entry is unchanged, and so is the last-store record of the losing set.
- R6: A dispatched load or store whose entry is valid, and whose set has a valid last-store record, gets dispWait high and dispDepTag equal to that record. A dispatched store with a valid entry then becomes its set's last-store record.
- R7: A store issue whose tag equals its set's last-store record invalidates that record. An issue with any other tag leaves the record unchanged.
- R8: chkReady is high when chkValid is high and at least one of these holds: chkStoreDone is high; a store issues in the same cycle with a tag equal to chkDepTag; or (retireTag − chkDepTag) mod 64 lies in 1..31.
- R9: The flush threshold is N = ceil(P·16/100), with P = 70 + 5·flushSel (flushSel above 5 counts as 95). In the cycle after the valid-entry count reaches N, both tables are emptied, so a load of a previously trained set no longer waits.
- R10: When a store dispatch and a matching store issue address the same set in one cycle, the dispatched store's tag remains as that set's last-store record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Memory instruction dispatched this cycle |
| dispIsStore | input | 1 | Dispatched instruction is a store |
| dispPc | input | 14 | Word PC of the dispatched instruction |
| dispTag | input | 6 | Sequence tag of the dispatched instruction |
| dispWait | output | 1 | Instruction must wait for an earlier store |
| dispDepTag | output | 6 | Tag of the store to wait for |
| stIssueValid | input | 1 | A store issues from the store queue |
| stIssuePc | input | 14 | Word PC of the issuing store |
| stIssueTag | input | 6 | Tag of the issuing store |
| trainValid | input | 1 | Ordering violation reported |
| trainLoadPc | input | 14 | Word PC of the violating load |
| trainStorePc | input | 14 | Word PC of the violating store |
| chkValid | input | 1 | Release check requested |
| chkDepTag | input | 6 | Tag of the store the load waits on |
| chkStoreDone | input | 1 | That store has already issued |
| retireTag | input | 6 | Tag of the next instruction to retire |
| chkReady | output | 1 | Waiting load may issue |
| flushSel | input | 3 | Flush threshold select |

## Verification
The assertions take for granted that tags are unique within the modular window. They also take for granted that a store dispatched twice in a row from one PC carries a new tag each time, and that the inputs stay idle while reset is held. The stimulus keeps to this by giving every dispatch its own tag well inside the 32-tag half window, and by driving only zeros during reset. Training events use PCs whose folded index the bench knows, so the entry each event writes is known ahead of time. The release sweep steps through every pair of retire tag and dependence tag.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  // Source of the identifier written by a training event
  typedef enum logic [1:0] {
    SRC_ALLOC = 2'd0,
    SRC_LOAD  = 2'd1,
    SRC_STORE = 2'd2,
    SRC_MIN   = 2'd3
  } idSrc_e;

  // Strobes from control to the tables
  typedef struct packed {
    logic   flush;
    logic   wrLd;
    logic   wrSt;
    idSrc_e idSrc;
  } sspStrobe_t;
endpackage

// File: rtl/sspCtl.sv
module sspCtl
  import ssp_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int SSID_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trainValid,
  input  logic              ldHit,
  input  logic              stHit,
  input  logic [SSID_W-1:0] ldId,
  input  logic [SSID_W-1:0] stId,
  input  logic              sameIdx,
  input  logic [2:0]        flushSel,
  output sspStrobe_t        strb,
  output logic [SSID_W-1:0] allocId
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int CNT_W   = IDX_W + 1;

  logic [CNT_W-1:0] validCnt;
  logic [1:0]       addCnt;
  logic [6:0]       pct;
  logic             flushNow;

  always_comb begin
    if (flushSel > 3'd5) pct = 7'd95;
    else                 pct = 7'(70 + 5 * int'(flushSel));
    flushNow = (int'(validCnt) * 100) >= (int'(pct) * ENTRIES);
  end

  // Four training rules; the smaller identifier wins a merge
  always_comb begin
    strb       = '0;
    strb.flush = flushNow;
    addCnt     = 2'd0;
    if (trainValid && !flushNow) begin
      unique case ({ldHit, stHit})
        2'b00: begin
          strb.wrLd  = 1'b1;
          strb.wrSt  = 1'b1;
          strb.idSrc = SRC_ALLOC;
          addCnt     = sameIdx ? 2'd1 : 2'd2;
        end
        2'b10: begin
          strb.wrSt  = 1'b1;
          strb.idSrc = SRC_LOAD;
          addCnt     = 2'd1;
        end
        2'b01: begin
          strb.wrLd  = 1'b1;
          strb.idSrc = SRC_STORE;
          addCnt     = 2'd1;
        end
        default: begin
          if (ldId != stId) begin
            strb.idSrc = SRC_MIN;
            if (ldId < stId) strb.wrSt = 1'b1;
            else             strb.wrLd = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      validCnt <= '0;
      allocId  <= '0;
    end else begin
      if (flushNow) validCnt <= '0;
      else          validCnt <= validCnt + CNT_W'(addCnt);
      if (strb.wrLd && strb.idSrc == SRC_ALLOC) allocId <= allocId + 1'b1;
    end
  end
endmodule

// File: rtl/sspTables.sv
module sspTables
  import ssp_pkg::*;
#(
  parameter int PC_W   = 14,
  parameter int IDX_W  = 4,
  parameter int SSID_W = 3,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sspStrobe_t        strb,
  input  logic [SSID_W-1:0] allocId,
  input  logic              dispValid,
  input  logic              dispIsStore,
  input  logic [PC_W-1:0]   dispPc,
  input  logic [TAG_W-1:0]  dispTag,
  output logic              dispHit,
  output logic              dispWait,
  output logic [TAG_W-1:0]  dispDepTag,
  input  logic              stIssueValid,
  input  logic [PC_W-1:0]   stIssuePc,
  input  logic [TAG_W-1:0]  stIssueTag,
  input  logic [PC_W-1:0]   trainLoadPc,
  input  logic [PC_W-1:0]   trainStorePc,
  output logic              ldHit,
  output logic              stHit,
  output logic [SSID_W-1:0] ldId,
  output logic [SSID_W-1:0] stId,
  output logic              sameIdx,
  input  logic              chkValid,
  input  logic [TAG_W-1:0]  chkDepTag,
  input  logic              chkStoreDone,
  input  logic [TAG_W-1:0]  retireTag,
  output logic              chkReady
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int SETS    = 1 << SSID_W;
  localparam int CHUNKS  = (PC_W + IDX_W - 1) / IDX_W;

  function automatic logic [IDX_W-1:0] foldPc(input logic [PC_W-1:0] pc);
    logic [CHUNKS*IDX_W-1:0] wide;
    logic [IDX_W-1:0]        acc;
    wide = (CHUNKS*IDX_W)'(pc);
    acc  = '0;
    for (int c = 0; c < CHUNKS; c++) acc ^= wide[c*IDX_W +: IDX_W];
    return acc;
  endfunction

  logic [ENTRIES-1:0] idV;
  logic [SSID_W-1:0]  idTab [ENTRIES];
  logic [SETS-1:0]    lastV;
  logic [TAG_W-1:0]   lastTag [SETS];

  logic [IDX_W-1:0]  dIdx, iIdx, lIdx, sIdx;
  logic [SSID_W-1:0] dSet, iSet, wrId;
  logic              issueKill, dispStWr, allocKill;
  logic [TAG_W-1:0]  ageDiff;

  always_comb begin
    dIdx    = foldPc(dispPc);
    iIdx    = foldPc(stIssuePc);
    lIdx    = foldPc(trainLoadPc);
    sIdx    = foldPc(trainStorePc);
    dSet    = idTab[dIdx];
    iSet    = idTab[iIdx];
    dispHit = idV[dIdx];
    ldHit   = idV[lIdx];
    stHit   = idV[sIdx];
    ldId    = idTab[lIdx];
    stId    = idTab[sIdx];
    sameIdx = (lIdx == sIdx);

    dispWait   = dispValid && dispHit && lastV[dSet];
    dispDepTag = dispWait ? lastTag[dSet] : '0;

    unique case (strb.idSrc)
      SRC_ALLOC: wrId = allocId;
      SRC_LOAD:  wrId = ldId;
      SRC_STORE: wrId = stId;
      default:   wrId = (ldId < stId) ? ldId : stId;
    endcase

    issueKill = stIssueValid && idV[iIdx] && lastV[iSet] && (lastTag[iSet] == stIssueTag);
    dispStWr  = dispValid && dispIsStore && dispHit;
    allocKill = strb.wrLd && (strb.idSrc == SRC_ALLOC);

    ageDiff  = retireTag - chkDepTag;
    chkReady = chkValid && (chkStoreDone ||
               (stIssueValid && stIssueTag == chkDepTag) ||
               (ageDiff != '0 && !ageDiff[TAG_W-1]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strb.flush) begin
      idV   <= '0;
      lastV <= '0;
    end else begin
      if (strb.wrLd) begin
        idV[lIdx]   <= 1'b1;
        idTab[lIdx] <= wrId;
      end
      if (strb.wrSt) begin
        idV[sIdx]   <= 1'b1;
        idTab[sIdx] <= wrId;
      end
      // later statements take priority: issue < dispatch < training
      if (issueKill) lastV[iSet] <= 1'b0;
      if (dispStWr) begin
        lastV[dSet]   <= 1'b1;
        lastTag[dSet] <= dispTag;
      end
      if (allocKill) lastV[allocId] <= 1'b0;
    end
  end
endmodule

// File: rtl/storeSetPredictor.sv
module storeSetPredictor
  import ssp_pkg::*;
#(
  parameter int PC_W   = 14,
  parameter int IDX_W  = 4,
  parameter int SSID_W = 3,
  parameter int TAG_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dispValid,
  input  logic             dispIsStore,
  input  logic [PC_W-1:0]  dispPc,
  input  logic [TAG_W-1:0] dispTag,
  output logic             dispWait,
  output logic [TAG_W-1:0] dispDepTag,
  input  logic             stIssueValid,
  input  logic [PC_W-1:0]  stIssuePc,
  input  logic [TAG_W-1:0] stIssueTag,
  input  logic             trainValid,
  input  logic [PC_W-1:0]  trainLoadPc,
  input  logic [PC_W-1:0]  trainStorePc,
  input  logic             chkValid,
  input  logic [TAG_W-1:0] chkDepTag,
  input  logic             chkStoreDone,
  input  logic [TAG_W-1:0] retireTag,
  output logic             chkReady,
  input  logic [2:0]       flushSel
);
  sspStrobe_t        strb;
  logic [SSID_W-1:0] allocId, ldId, stId;
  logic              ldHit, stHit, sameIdx, dispHit;

  sspCtl #(.IDX_W(IDX_W), .SSID_W(SSID_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .trainValid(trainValid),
    .ldHit(ldHit), .stHit(stHit), .ldId(ldId), .stId(stId),
    .sameIdx(sameIdx), .flushSel(flushSel), .strb(strb), .allocId(allocId)
  );

  sspTables #(.PC_W(PC_W), .IDX_W(IDX_W), .SSID_W(SSID_W), .TAG_W(TAG_W)) u_tab (
    .clk(clk), .rst_n(rst_n), .strb(strb), .allocId(allocId),
    .dispValid(dispValid), .dispIsStore(dispIsStore), .dispPc(dispPc),
    .dispTag(dispTag), .dispHit(dispHit), .dispWait(dispWait),
    .dispDepTag(dispDepTag), .stIssueValid(stIssueValid),
    .stIssuePc(stIssuePc), .stIssueTag(stIssueTag),
    .trainLoadPc(trainLoadPc), .trainStorePc(trainStorePc),
    .ldHit(ldHit), .stHit(stHit), .ldId(ldId), .stId(stId),
    .sameIdx(sameIdx), .chkValid(chkValid), .chkDepTag(chkDepTag),
    .chkStoreDone(chkStoreDone), .retireTag(retireTag), .chkReady(chkReady)
  );
endmodule

// File: rtl/sspChecker.sv
module sspChecker
  import ssp_pkg::*;
#(
  parameter int PC_W   = 14,
  parameter int SSID_W = 3,
  parameter int TAG_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input sspStrobe_t        strb,
  input logic              trainValid,
  input logic              ldHit,
  input logic              stHit,
  input logic [SSID_W-1:0] ldId,
  input logic [SSID_W-1:0] stId,
  input logic              dispValid,
  input logic              dispIsStore,
  input logic              dispHit,
  input logic [PC_W-1:0]   dispPc,
  input logic [TAG_W-1:0]  dispTag,
  input logic              dispWait,
  input logic [TAG_W-1:0]  dispDepTag,
  input logic              chkValid,
  input logic              chkStoreDone,
  input logic              chkReady
);
  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.flush |=> !dispWait);

  // R3
  alloc_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trainValid && !strb.flush && !ldHit && !stHit)
      |-> (strb.wrLd && strb.wrSt && strb.idSrc == SRC_ALLOC));

  // R5
  merge_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trainValid && !strb.flush && ldHit && stHit && ldId < stId)
      |-> (strb.wrSt && !strb.wrLd && strb.idSrc == SRC_MIN));

  // R6
  store_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dispValid && dispIsStore && dispHit && !trainValid && !strb.flush)
      && dispValid && dispPc == $past(dispPc))
      |-> (dispWait && dispDepTag == $past(dispTag)));

  // R8
  ready_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chkValid && chkStoreDone) |-> chkReady);
endmodule

bind storeSetPredictor sspChecker #(.PC_W(PC_W), .SSID_W(SSID_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .strb(strb), .trainValid(trainValid),
  .ldHit(ldHit), .stHit(stHit), .ldId(ldId), .stId(stId),
  .dispValid(dispValid), .dispIsStore(dispIsStore), .dispHit(dispHit),
  .dispPc(dispPc), .dispTag(dispTag), .dispWait(dispWait),
  .dispDepTag(dispDepTag), .chkValid(chkValid),
  .chkStoreDone(chkStoreDone), .chkReady(chkReady)
);

// File: tb/sim_storeSetPredictor.sv
module sim_storeSetPredictor;
  localparam int CLK_P = 10;
  localparam int PC_W  = 14;
  localparam int TAG_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dispValid = 0, dispIsStore = 0, stIssueValid = 0, trainValid = 0;
  logic chkValid = 0, chkStoreDone = 0;
  logic [PC_W-1:0]  dispPc = '0, stIssuePc = '0, trainLoadPc = '0, trainStorePc = '0;
  logic [TAG_W-1:0] dispTag = '0, stIssueTag = '0, chkDepTag = '0, retireTag = '0;
  logic [2:0]       flushSel = 3'd5;
  logic             dispWait, chkReady;
  logic [TAG_W-1:0] dispDepTag;

  int nChk = 0, nFail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  storeSetPredictor u0 (
    .clk(clk), .rst_n(rst_n), .dispValid(dispValid), .dispIsStore(dispIsStore),
    .dispPc(dispPc), .dispTag(dispTag), .dispWait(dispWait), .dispDepTag(dispDepTag),
    .stIssueValid(stIssueValid), .stIssuePc(stIssuePc), .stIssueTag(stIssueTag),
    .trainValid(trainValid), .trainLoadPc(trainLoadPc), .trainStorePc(trainStorePc),
    .chkValid(chkValid), .chkDepTag(chkDepTag), .chkStoreDone(chkStoreDone),
    .retireTag(retireTag), .chkReady(chkReady), .flushSel(flushSel)
  );

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic train(input int l, input int s);
    trainValid = 1; trainLoadPc = PC_W'(l); trainStorePc = PC_W'(s);
    tick();
    trainValid = 0;
  endtask

  task automatic disp(input bit st, input int pcv, input int tag,
                      input bit expW, input int expD, input string req);
    dispValid = 1; dispIsStore = st; dispPc = PC_W'(pcv); dispTag = TAG_W'(tag);
    #1;
    check(req, int'(dispWait), int'(expW));
    if (expW) check(req, int'(dispDepTag), expD);
    tick();
    dispValid = 0;
  endtask

  task automatic issue(input int pcv, input int tag);
    stIssueValid = 1; stIssuePc = PC_W'(pcv); stIssueTag = TAG_W'(tag);
    tick();
    stIssueValid = 0;
  endtask

  initial begin
    doReset();
    // R1: nothing waits, and an unpassed tag is not released
    disp(0, 0, 1, 0, 0, "R1 load after reset");
    chkValid = 1; #1; check("R1 release idle", int'(chkReady), 0); chkValid = 0;

    train(1, 2);                                  // fresh id 0
    disp(1, 2, 5, 0, 0, "R6 first store of set");
    disp(0, 1, 7, 1, 5, "R3 load waits on store");
    disp(1, 2, 9, 1, 5, "R6 store chain");
    issue(2, 5);
    disp(0, 1, 10, 1, 9, "R7 stale issue ignored");
    issue(2, 9);
    disp(0, 1, 10, 0, 0, "R7 matching issue clears");
    train(3, 2);                                  // only store valid
    disp(1, 2, 11, 0, 0, "R6 store after clear");
    disp(0, 3, 12, 1, 11, "R4 load joins store set");
    train(4, 5);                                  // fresh id 1
    train(1, 6);                                  // only load valid
    disp(1, 6, 13, 1, 11, "R4 store joins load set");
    disp(1, 5, 20, 0, 0, "R3 fresh set empty");
    train(4, 2);                                  // load id1 vs store id0
    disp(0, 4, 22, 1, 13, "R5 load entry merged");
    disp(1, 5, 21, 1, 20, "R5 losing set kept");
    train(5, 1);                                  // load id1 vs store id0
    disp(0, 5, 23, 1, 13, "R5 merge other side");
    disp(0, 'h017, 24, 1, 13, "R2 folded index alias");
    disp(0, 'h011, 25, 0, 0, "R2 folded index empty");

    // R10: dispatch and matching issue to set 0 in one cycle
    stIssueValid = 1; stIssuePc = PC_W'(6); stIssueTag = TAG_W'(13);
    disp(1, 2, 30, 1, 13, "R10 dispatch same cycle");
    stIssueValid = 0;
    disp(0, 1, 31, 1, 30, "R10 dispatch wins");

    // R9: threshold sweep, including the clamp above 5
    for (int sel = 0; sel <= 6; sel++) begin
      int p, thr, cnt;
      p   = (sel > 5) ? 95 : 70 + 5 * sel;
      thr = (p * 16 + 99) / 100;
      cnt = 0;
      flushSel = 3'(sel);
      doReset();
      for (int k = 0; k < 8; k++) begin
        train(2 * k, 2 * k + 1);
        cnt += 2;
        disp(1, 2 * k + 1, 40 + k, 0, 0, "R9 fresh set store");
        if (cnt >= thr) begin
          disp(0, 2 * k, 50, 0, 0, "R9 flushed at threshold");
          disp(0, 0, 51, 0, 0, "R9 first set flushed");
          break;
        end else begin
          disp(0, 2 * k, 50, 1, 40 + k, "R9 below threshold");
        end
      end
    end
    flushSel = 3'd5;

    // R8: exhaustive release sweep by modular age
    chkValid = 1;
    for (int r = 0; r < 64; r++) begin
      for (int d = 0; d < 64; d++) begin
        int diff;
        retireTag = TAG_W'(r); chkDepTag = TAG_W'(d);
        #1;
        diff = (r - d + 64) % 64;
        check("R8 retire age", int'(chkReady), (diff != 0 && diff < 32) ? 1 : 0);
      end
    end
    retireTag = 6'd3; chkDepTag = 6'd3;
    chkStoreDone = 1; #1; check("R8 store done", int'(chkReady), 1);
    chkStoreDone = 0; #1; check("R8 not yet", int'(chkReady), 0);
    stIssueValid = 1; stIssueTag = 6'd3; stIssuePc = '0;
    #1; check("R8 same cycle issue", int'(chkReady), 1);
    stIssueTag = 6'd4; #1; check("R8 other issue", int'(chkReady), 0);
    chkValid = 0; stIssueTag = 6'd3; #1; check("R8 no request", int'(chkReady), 0);
    stIssueValid = 0;
    tick();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end
endmodule